// File: doc/BRIEF.md
# Turbo Interleaver Address Generator (QPP / ARP)

This block produces interleaved addresses for a turbo decoder on the fly, one per clock, for consecutive positions x = x0, x0+1, ... of a code block of length N. No permutation table, multiplier or divider is used. Two modular adders, each adding two operands below N and conditionally subtracting N, are shared between a quadratic permutation polynomial (QPP) mode and an almost-regular permutation (ARP) mode.

A start pulse latches the configuration: block length, mode, polynomial coefficients or ARP constants, and seed values for the starting position. From the start position on, each advance strobe steps x by one. Because a sub-block decoder may begin anywhere in the block, the caller provides the seeds for x0 and the low two bits of x0. In ARP mode the block also flags the positions whose bit couple must be exchanged before use.

Top module: `ilv_addr_gen`

## Requirements
- R1: After reset, `valid_o`, `addr_o` and `swap_o` are all 0.
- R2: In QPP mode (`mode_i`=0), the cycle after `start_i` the design raises `valid_o` and sets `addr_o` to `seed_main_i`, which the caller sets to (f2·x0² + f1·x0) mod N. `seed_step_i` carries (2·f2·x0 + f1 + f2) mod N.
- R3: In QPP mode, each cycle with `adv_i` high advances x by one, and the next cycle's `addr_o` equals (f2·x² + f1·x) mod N.
- R4: When `start_i` and `adv_i` are low, `addr_o` and `swap_o` hold. Before the first start, `adv_i` has no effect and `valid_o` stays 0.
- R5: In ARP mode (`mode_i`=1), `seed_main_i` carries λ(x0) = P0·x0 mod N, and the cycle after `start_i` `addr_o` equals (λ(x0) + Q(x0)) mod N. Q(x) is 1 when x mod 4 = 0, 1+N/2+P1 when it is 1, 1+P2 when it is 2, and 1+N/2+P3 when it is 3. `start_phase_i` gives x0 mod 4.
- R6: In ARP mode, each cycle with `adv_i` high advances x by one, and the next `addr_o` equals (P0·x + Q(x)) mod N.
- R7: `swap_o` is 1 exactly when the mode is ARP and the current x is odd. In QPP mode it is always 0.
- R8: When `start_i` and `adv_i` are high in the same cycle, the start wins. The output is the seeded value for the new x0, and no advance is applied.
- R9: While `valid_o` is high, `addr_o` < N. This holds for every N from 4 to 6144.
- R10: The configuration (N, mode, f1, f2, P0..P3) is taken only at `start_i`. Changing those inputs afterwards does not change the address sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = QPP, 1 = ARP |
| blk_len_i | input | 13 | Block length N |
| f1_i | input | 13 | QPP linear coefficient, below N |
| f2_i | input | 13 | QPP quadratic coefficient, below N |
| p0_i | input | 13 | ARP stride P0, below N |
| p1_i | input | 13 | ARP offset P1, below N |
| p2_i | input | 13 | ARP offset P2, below N |
| p3_i | input | 13 | ARP offset P3, below N |
| start_i | input | 1 | Load configuration and seeds |
| start_phase_i | input | 2 | x0 mod 4 |
| seed_main_i | input | 13 | QPP: Π(x0); ARP: λ(x0) |
| seed_step_i | input | 13 | QPP: Γ(x0); ignored in ARP |
| adv_i | input | 1 | Step x by one |
| addr_o | output | 13 | Interleaved address Π(x) |
| swap_o | output | 1 | ARP couple exchange for the current x |
| valid_o | output | 1 | Address sequence running |

## Verification
A start and an advance can arrive in the same cycle. Both would rewrite the address and the accumulator register, so the design needs a defined winner. The bench runs a sequence for a while, then drives both strobes high at one edge with fresh seeds for a different x0. It expects the next address to be the seeded value, not the advanced one, and expects the following advances to continue from the new x0. The chained adders are also stressed near the largest block length, where every sum crosses N many times.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int unsigned ADDR_W = 13;

  typedef enum logic {
    MODE_QPP = 1'b0,
    MODE_ARP = 1'b1
  } ilv_mode_e;
endpackage

// File: rtl/ilv_modacc.sv
// (a + b) mod n for a, b < n: one add, one subtract, pick by sign
module ilv_modacc #(
  parameter int unsigned W = 13
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] n_i,
  output logic [W-1:0] r_o
);
  logic [W:0]   sum;
  logic [W+1:0] diff;

  always_comb begin
    sum  = {1'b0, a_i} + {1'b0, b_i};
    diff = {1'b0, sum} - {2'b00, n_i};
    r_o  = diff[W+1] ? sum[W-1:0] : diff[W-1:0];
  end
endmodule

// File: rtl/ilv_qtab.sv
// ARP phase offsets, reduced mod N once at load
module ilv_qtab #(
  parameter int unsigned W      = 13,
  parameter int unsigned PHASES = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          load_i,
  input  logic [W-1:0]                  n_i,
  input  logic [PHASES-2:0][W-1:0]      offs_i,
  output logic [PHASES-1:0][W-1:0]      q_new_o,
  output logic [PHASES-1:0][W-1:0]      q_o
);
  logic [W-1:0] half_p1;
  logic [W-1:0] one_w;

  assign half_p1 = (n_i >> 1) + W'(1);
  assign one_w   = W'(1);
  assign q_new_o[0] = one_w;

  for (genvar k = 1; k < PHASES; k++) begin : g_ph
    logic [W-1:0] base;
    assign base = (k % 2 == 1) ? half_p1 : one_w;
    ilv_modacc #(.W(W)) i_red (
      .a_i(base),
      .b_i(offs_i[k-1]),
      .n_i(n_i),
      .r_o(q_new_o[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= q_new_o;
  end
endmodule

// File: rtl/ilv_addr_gen.sv
module ilv_addr_gen
  import ilv_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  input  logic [AW-1:0] blk_len_i,
  input  logic [AW-1:0] f1_i,
  input  logic [AW-1:0] f2_i,
  input  logic [AW-1:0] p0_i,
  input  logic [AW-1:0] p1_i,
  input  logic [AW-1:0] p2_i,
  input  logic [AW-1:0] p3_i,
  input  logic          start_i,
  input  logic [1:0]    start_phase_i,
  input  logic [AW-1:0] seed_main_i,
  input  logic [AW-1:0] seed_step_i,
  input  logic          adv_i,
  output logic [AW-1:0] addr_o,
  output logic          swap_o,
  output logic          valid_o
);
  localparam int unsigned PHASES = 4;

  ilv_mode_e     mode_q;
  logic [AW-1:0] n_q, g_q, p0_q;
  logic [AW-1:0] addr_q, acc_q;
  logic [1:0]    ph_q, ph_nx;
  logic          valid_q;

  logic [AW-1:0] g_new, acc1_b, acc1_r;
  logic [AW-1:0] acc2_a, acc2_b, acc2_n, acc2_r;
  logic [PHASES-1:0][AW-1:0] q_new, q_q;
  logic          step;

  assign ph_nx = ph_q + 2'd1;
  assign step  = adv_i && valid_q && !start_i;

  // g = 2*f2 mod N
  ilv_modacc #(.W(AW)) i_gcalc (
    .a_i(f2_i), .b_i(f2_i), .n_i(blk_len_i), .r_o(g_new)
  );

  ilv_qtab #(.W(AW), .PHASES(PHASES)) i_qtab (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start_i),
    .n_i    (blk_len_i),
    .offs_i ({p3_i, p2_i, p1_i}),
    .q_new_o(q_new),
    .q_o    (q_q)
  );

  // first accumulator: Gamma += g (QPP) or lambda += P0 (ARP)
  assign acc1_b = (mode_q == MODE_ARP) ? p0_q : g_q;
  ilv_modacc #(.W(AW)) i_acc1 (
    .a_i(acc_q), .b_i(acc1_b), .n_i(n_q), .r_o(acc1_r)
  );

  // second accumulator: Pi += Gamma (QPP) or lambda_next + Q (ARP)
  always_comb begin
    if (start_i) begin
      acc2_a = seed_main_i;
      acc2_b = q_new[start_phase_i];
      acc2_n = blk_len_i;
    end else if (mode_q == MODE_ARP) begin
      acc2_a = acc1_r;
      acc2_b = q_q[ph_nx];
      acc2_n = n_q;
    end else begin
      acc2_a = addr_q;
      acc2_b = acc_q;
      acc2_n = n_q;
    end
  end
  ilv_modacc #(.W(AW)) i_acc2 (
    .a_i(acc2_a), .b_i(acc2_b), .n_i(acc2_n), .r_o(acc2_r)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_QPP;
      n_q    <= '0;
      g_q    <= '0;
      p0_q   <= '0;
    end else if (start_i) begin
      mode_q <= ilv_mode_e'(mode_i);
      n_q    <= blk_len_i;
      g_q    <= g_new;
      p0_q   <= p0_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      acc_q   <= '0;
      ph_q    <= '0;
      valid_q <= 1'b0;
    end else if (start_i) begin
      valid_q <= 1'b1;
      ph_q    <= start_phase_i;
      acc_q   <= (mode_i == MODE_ARP) ? seed_main_i : seed_step_i;
      addr_q  <= (mode_i == MODE_ARP) ? acc2_r : seed_main_i;
    end else if (step) begin
      ph_q   <= ph_nx;
      acc_q  <= acc1_r;
      addr_q <= acc2_r;
    end
  end

  assign addr_o  = addr_q;
  assign swap_o  = (mode_q == MODE_ARP) && ph_q[0];
  assign valid_o = valid_q;

  // R9
  addr_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (addr_o < n_q));

  // R4
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !start_i) |=> ($stable(addr_o) && $stable(swap_o)));

  // R7
  swap_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && adv_i && !start_i && mode_q == MODE_ARP) |=> (swap_o != $past(swap_o)));

  // R2
  start_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o);
endmodule

// File: tb/test_ilv_addr_gen.sv
module test_ilv_addr_gen;
  localparam int AW = 13;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode = 1'b0;
  logic [AW-1:0] blk_len = '0, f1 = '0, f2 = '0;
  logic [AW-1:0] p0 = '0, p1 = '0, p2 = '0, p3 = '0;
  logic          start = 1'b0, adv = 1'b0;
  logic [1:0]    start_phase = '0;
  logic [AW-1:0] seed_main = '0, seed_step = '0;
  logic [AW-1:0] addr;
  logic          swap, valid;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // bench-side configuration
  int     c_mode, c_n, c_f1, c_f2;
  int     c_p[4];
  longint c_x;

  always #2 clk = ~clk;

  ilv_addr_gen i_ilv_addr_gen (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .blk_len_i(blk_len),
    .f1_i(f1), .f2_i(f2), .p0_i(p0), .p1_i(p1), .p2_i(p2), .p3_i(p3),
    .start_i(start), .start_phase_i(start_phase),
    .seed_main_i(seed_main), .seed_step_i(seed_step),
    .adv_i(adv), .addr_o(addr), .swap_o(swap), .valid_o(valid)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint q_of(longint x);
    longint k = x % 4;
    longint v = 1 + ((k % 2 == 1) ? c_n / 2 : 0) + ((k == 0) ? 0 : c_p[k]);
    return v % c_n;
  endfunction

  function automatic longint exp_addr(longint x);
    if (c_mode == 0)
      return (longint'(c_f2) * x * x + longint'(c_f1) * x) % c_n;
    return ((longint'(c_p[0]) * x) % c_n + q_of(x)) % c_n;
  endfunction

  function automatic bit exp_swap(longint x);
    return (c_mode == 1) && (x % 2 == 1);
  endfunction

  task automatic drive_cfg(input longint x0);
    mode        = c_mode[0];
    blk_len     = AW'(c_n);
    f1          = AW'(c_f1);
    f2          = AW'(c_f2);
    p0          = AW'(c_p[0]);
    p1          = AW'(c_p[1]);
    p2          = AW'(c_p[2]);
    p3          = AW'(c_p[3]);
    start_phase = 2'(x0 % 4);
    if (c_mode == 0) begin
      seed_main = AW'(exp_addr(x0));
      seed_step = AW'((2 * longint'(c_f2) * x0 + c_f1 + c_f2) % c_n);
    end else begin
      seed_main = AW'((longint'(c_p[0]) * x0) % c_n);
      seed_step = AW'(0);
    end
  endtask

  task automatic check_now(input string req);
    chk(addr == AW'(exp_addr(c_x)), req, addr, exp_addr(c_x));
    chk(swap == exp_swap(c_x), "R7 swap", swap, exp_swap(c_x));
    chk(valid == 1'b1, "R2 valid", valid, 1);
  endtask

  task automatic do_start(input longint x0, input string req);
    @(negedge clk);
    drive_cfg(x0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    c_x = x0;
    check_now(req);
  endtask

  task automatic do_adv(input int steps, input string req);
    adv = 1'b1;
    for (int i = 0; i < steps; i++) begin
      @(negedge clk);
      c_x++;
      check_now(req);
    end
    adv = 1'b0;
  endtask

  task automatic t_reset();
    chk(valid == 1'b0, "R1 valid", valid, 0);
    chk(addr == '0, "R1 addr", addr, 0);
    chk(swap == 1'b0, "R1 swap", swap, 0);
    // R4: advance before any start is ignored
    @(negedge clk);
    adv = 1'b1;
    repeat (3) @(negedge clk);
    adv = 1'b0;
    chk(valid == 1'b0, "R4 pre-start valid", valid, 0);
    chk(addr == '0, "R4 pre-start addr", addr, 0);
  endtask

  task automatic t_qpp(input int n, input int a1, input int a2, input longint x0, input int steps);
    c_mode = 0; c_n = n; c_f1 = a1; c_f2 = a2;
    c_p[0] = 0; c_p[1] = 0; c_p[2] = 0; c_p[3] = 0;
    do_start(x0, "R2 qpp seed");
    do_adv(steps, "R3 qpp step");
  endtask

  task automatic t_arp(input int n, input int a0, input int a1, input int a2, input int a3,
                       input longint x0, input int steps);
    c_mode = 1; c_n = n; c_f1 = 0; c_f2 = 0;
    c_p[0] = a0; c_p[1] = a1; c_p[2] = a2; c_p[3] = a3;
    do_start(x0, "R5 arp seed");
    do_adv(steps, "R6 arp step");
  endtask

  task automatic t_hold();
    logic [AW-1:0] a0;
    logic s0;
    t_arp(48, 13, 2, 20, 31, 5, 3);
    a0 = addr; s0 = swap;
    repeat (5) begin
      @(negedge clk);
      chk(addr == a0, "R4 hold addr", addr, a0);
      chk(swap == s0, "R4 hold swap", swap, s0);
    end
    do_adv(4, "R4 resume");
  endtask

  task automatic t_collide();
    t_qpp(40, 3, 10, 0, 6);
    @(negedge clk);
    drive_cfg(23);
    adv   = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    adv   = 1'b0;
    c_x = 23;
    check_now("R8 start wins");
    do_adv(5, "R8 continue");
    // ARP collision: phase must follow the new x0
    t_arp(48, 13, 2, 20, 31, 2, 3);
    @(negedge clk);
    drive_cfg(9);
    adv   = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    adv   = 1'b0;
    c_x = 9;
    check_now("R8 arp start wins");
    do_adv(4, "R8 arp continue");
  endtask

  task automatic t_latch();
    t_qpp(248, 3, 62, 10, 2);
    @(negedge clk);
    mode = 1'b1; blk_len = AW'(7); f1 = AW'(1); f2 = AW'(5); p0 = AW'(3);
    do_adv(10, "R10 qpp latched");
    t_arp(2400, 97, 1000, 2000, 2399, 6, 2);
    @(negedge clk);
    mode = 1'b0; blk_len = AW'(100); p0 = AW'(1); p1 = AW'(7); p2 = AW'(9); p3 = AW'(11);
    do_adv(10, "R10 arp latched");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_qpp(40, 3, 10, 0, 45);
    t_qpp(40, 3, 10, 17, 30);
    t_qpp(6144, 263, 480, 6100, 80);   // R9 largest block
    t_qpp(6144, 6143, 6143, 6143, 20); // R9 operands at N-1
    t_arp(48, 13, 2, 20, 31, 0, 40);
    t_arp(48, 13, 2, 20, 31, 7, 25);
    t_arp(6144, 6143, 6143, 6143, 6143, 3, 30); // R9
    t_arp(2400, 97, 1000, 2000, 2399, 1, 30);
    t_hold();
    t_collide();
    t_latch();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule